// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block sits between a bank of interrupt request lines and a small RISC core. Each request line has its own priority level, supplied as a flat input vector. Every cycle the controller picks the strongest eligible request and, when the core can take an interrupt, accepts it. Acceptance raises a one-cycle acknowledge carrying the source index and its level. On the same edge the running mask level becomes that level and an exception-level flag is set. That flag holds off any further acceptance until the core returns or software clears it.

A return strobe from the core clears the exception-level flag. It also restores the mask level that was in force before the most recent acceptance. Those saved levels live in a short stack that deepens by one entry with each nested acceptance. A software enable flag gates acceptance independently of the hardware-driven exception-level flag. A small register port lets software read and write the mask level and both flags, and read the stack depth and a sticky overflow indication. Software can set the exception-level flag near the end of a handler. The return then clears it, so interrupts reopen at exactly the moment of return.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After synchronous reset the mask level is 0, the exception-level flag is 0, the software enable is 0, the overflow flag is 0, the acknowledge is low and the stack depth reads 0.
- R2: Only a request whose line is high and whose level is non-zero is eligible. Among eligible requests the highest level wins, and equal levels go to the lowest source index.
- R3: A request is accepted only in a cycle where the software enable is 1, the exception-level flag is 0 and the return strobe is low.
- R4: A request is eligible only if its level is strictly greater than the current mask level, so an equal level never preempts.
- R5: An acceptance at clock edge E drives `ack` high for exactly one cycle after E. In that cycle `ack_id` and `ack_lvl` hold the winner, `cur_mask` equals the winner's level and `exl` is 1.
- R6: The return strobe clears the exception-level flag on the next edge. If the stack is not empty, the most recently saved level is popped into the mask. If the stack is empty, the mask keeps its value.
- R7: Every acceptance pushes the mask level it replaces onto a stack of STK_DEPTH entries (4 by default). A push into a full stack discards the pushed level, leaves depth and contents unchanged, and sets `stk_ovf`, which stays 1 until reset.
- R8: Register port, with writes taking effect at the edge where `sw_wr` is high:
  - Address 0 holds the mask level in bits [2:0].
  - Address 1 holds the flags: bit 0 is the software enable, bit 1 is the exception-level flag, and bit 2 is overflow, which is read-only.
  - Address 2 reads the stack depth and ignores writes.
  - `sw_rdata` is registered: it shows the addressed register as it stood in the cycle `sw_addr` was presented, one edge later.
- R9: No request is accepted in a cycle where `sw_wr` is high. When a return and a register write occur in the same cycle, the return's effect on the exception-level flag and the mask takes precedence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | N_SRC | Request lines, one per source |
| irq_prio | input | N_SRC*LVL_W | Level of source i in bits [i*LVL_W +: LVL_W] |
| eret | input | 1 | Exception-return strobe, one cycle per return |
| sw_wr | input | 1 | Register write enable |
| sw_addr | input | 2 | Register address (0 mask, 1 flags, 2 depth) |
| sw_wdata | input | REG_W | Register write data |
| sw_rdata | output | REG_W | Registered read data |
| ack | output | 1 | One-cycle acceptance pulse |
| ack_id | output | IDW | Index of the accepted source |
| ack_lvl | output | LVL_W | Level of the accepted source |
| cur_mask | output | LVL_W | Current mask level |
| exl | output | 1 | Exception-level flag |
| ie | output | 1 | Software enable flag |
| stk_ovf | output | 1 | Sticky stack overflow flag |

## Verification
Each result is due a fixed number of edges after its cause:
- Inputs applied before edge E lead to acceptance at E. The acknowledge, the mask update and the exception-level flag are all visible after E, and the acknowledge is gone after E+1.
- A return or a register write shows its effect after the edge on which it is held.
- Read data appears one edge after the address.

The bench drives every input on the falling edge and samples on the next falling edge after the relevant rising edge, so each check lands in the first cycle its value is due. A sweep over all request patterns and all mask levels compares the winner with a level computed arithmetically in the bench. Directed sequences cover nesting, return with an empty stack and overflow.

// File: rtl/nic_pkg.sv
package nic_pkg;
  typedef enum logic [1:0] {
    RA_MASK  = 2'd0,
    RA_FLAGS = 2'd1,
    RA_DEPTH = 2'd2
  } nic_addr_e;

  localparam int FLAG_IE  = 0;
  localparam int FLAG_EXL = 1;
  localparam int FLAG_OVF = 2;
endpackage

// File: rtl/nic_arbiter.sv
module nic_arbiter #(
  parameter int N_SRC = 8,
  parameter int LVL_W = 3,
  localparam int IDW  = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0]       req,
  input  logic [N_SRC*LVL_W-1:0] prio,
  input  logic [LVL_W-1:0]       floor_lvl,
  output logic                   win_vld,
  output logic [IDW-1:0]         win_id,
  output logic [LVL_W-1:0]       win_lvl
);
  logic [LVL_W-1:0] lvl_arr [N_SRC];
  logic [N_SRC-1:0] elig;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign lvl_arr[g] = prio[g*LVL_W +: LVL_W];
    assign elig[g]    = req[g] && (lvl_arr[g] != '0) && (lvl_arr[g] > floor_lvl);
  end

  // Ascending scan with strict compare: lowest index keeps a tie.
  always_comb begin
    win_vld = 1'b0;
    win_id  = '0;
    win_lvl = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (elig[i] && (!win_vld || lvl_arr[i] > win_lvl)) begin
        win_vld = 1'b1;
        win_id  = IDW'(i);
        win_lvl = lvl_arr[i];
      end
    end
  end
endmodule

// File: rtl/nic_lvl_stack.sv
module nic_lvl_stack #(
  parameter int DEPTH = 4,
  parameter int W     = 3,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  top,
  output logic [CW-1:0] count,
  output logic          ovf
);
  logic [W-1:0] mem [DEPTH];
  logic         full;
  logic         empty;
  logic [PW-1:0] top_idx;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign top_idx = PW'(count - CW'(1));
  assign top     = mem[top_idx];

  // Storage without reset so it can map to distributed RAM.
  always_ff @(posedge clk) begin
    if (push && !full) mem[PW'(count)] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      ovf   <= 1'b0;
    end else if (push) begin
      if (full) ovf   <= 1'b1;
      else      count <= count + CW'(1);
    end else if (pop && !empty) begin
      count <= count - CW'(1);
    end
  end
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
  parameter int N_SRC     = 8,
  parameter int LVL_W     = 3,
  parameter int STK_DEPTH = 4,
  localparam int IDW      = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int CW       = $clog2(STK_DEPTH + 1),
  localparam int REG_W    = (LVL_W > CW) ? ((LVL_W > 3) ? LVL_W : 3) : ((CW > 3) ? CW : 3)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_SRC-1:0]       irq_req,
  input  logic [N_SRC*LVL_W-1:0] irq_prio,
  input  logic                   eret,
  input  logic                   sw_wr,
  input  logic [1:0]             sw_addr,
  input  logic [REG_W-1:0]       sw_wdata,
  output logic [REG_W-1:0]       sw_rdata,
  output logic                   ack,
  output logic [IDW-1:0]         ack_id,
  output logic [LVL_W-1:0]       ack_lvl,
  output logic [LVL_W-1:0]       cur_mask,
  output logic                   exl,
  output logic                   ie,
  output logic                   stk_ovf
);
  import nic_pkg::*;

  logic             win_vld;
  logic [IDW-1:0]   win_id;
  logic [LVL_W-1:0] win_lvl;
  logic             accept;
  logic             pop;
  logic [LVL_W-1:0] stk_top;
  logic [CW-1:0]    stk_cnt;
  nic_addr_e        addr_e;
  logic [REG_W-1:0] rd_mux;

  nic_arbiter #(.N_SRC(N_SRC), .LVL_W(LVL_W)) u_arb (
    .req       (irq_req),
    .prio      (irq_prio),
    .floor_lvl (cur_mask),
    .win_vld   (win_vld),
    .win_id    (win_id),
    .win_lvl   (win_lvl)
  );

  assign accept = win_vld && ie && !exl && !eret && !sw_wr;
  assign pop    = eret && (stk_cnt != '0);

  nic_lvl_stack #(.DEPTH(STK_DEPTH), .W(LVL_W)) u_stk (
    .clk   (clk),
    .rst   (rst),
    .push  (accept),
    .pop   (pop),
    .din   (cur_mask),
    .top   (stk_top),
    .count (stk_cnt),
    .ovf   (stk_ovf)
  );

  assign addr_e = nic_addr_e'(sw_addr);

  always_comb begin
    rd_mux = '0;
    case (addr_e)
      RA_MASK:  rd_mux = REG_W'(cur_mask);
      RA_FLAGS: begin
        rd_mux[FLAG_IE]  = ie;
        rd_mux[FLAG_EXL] = exl;
        rd_mux[FLAG_OVF] = stk_ovf;
      end
      RA_DEPTH: rd_mux = REG_W'(stk_cnt);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_mask <= '0;
      exl      <= 1'b0;
      ie       <= 1'b0;
      ack      <= 1'b0;
      ack_id   <= '0;
      ack_lvl  <= '0;
      sw_rdata <= '0;
    end else begin
      ack      <= accept;
      sw_rdata <= rd_mux;
      if (accept) begin
        ack_id   <= win_id;
        ack_lvl  <= win_lvl;
        cur_mask <= win_lvl;
        exl      <= 1'b1;
      end
      if (sw_wr) begin
        case (addr_e)
          RA_MASK:  cur_mask <= sw_wdata[LVL_W-1:0];
          RA_FLAGS: begin
            ie  <= sw_wdata[FLAG_IE];
            exl <= sw_wdata[FLAG_EXL];
          end
          default: ;
        endcase
      end
      // Return has the last word on the flag and the mask.
      if (eret) begin
        exl <= 1'b0;
        if (pop) cur_mask <= stk_top;
      end
    end
  end
endmodule

// File: rtl/nic_checker.sv
module nic_checker #(
  parameter int LVL_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             eret,
  input logic             sw_wr,
  input logic             ack,
  input logic [LVL_W-1:0] ack_lvl,
  input logic [LVL_W-1:0] cur_mask,
  input logic             exl,
  input logic             ie,
  input logic             stk_ovf
);
  p_ack_single_r5: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  p_ack_state_r5: assert property (@(posedge clk) disable iff (rst)
    ack |-> (exl && cur_mask == ack_lvl));

  p_ack_nonzero_r2: assert property (@(posedge clk) disable iff (rst)
    ack |-> (ack_lvl != '0));

  p_ack_above_mask_r4: assert property (@(posedge clk) disable iff (rst)
    ack |-> (ack_lvl > $past(cur_mask)));

  p_ack_gated_r3: assert property (@(posedge clk) disable iff (rst)
    ack |-> ($past(ie) && !$past(exl) && !$past(eret)));

  p_no_ack_on_write_r9: assert property (@(posedge clk) disable iff (rst)
    ack |-> !$past(sw_wr));

  p_eret_clears_r6: assert property (@(posedge clk) disable iff (rst)
    eret |=> !exl);

  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    stk_ovf |=> stk_ovf);
endmodule

bind nest_irq_ctrl nic_checker #(.LVL_W(LVL_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .eret     (eret),
  .sw_wr    (sw_wr),
  .ack      (ack),
  .ack_lvl  (ack_lvl),
  .cur_mask (cur_mask),
  .exl      (exl),
  .ie       (ie),
  .stk_ovf  (stk_ovf)
);

// File: tb/nest_irq_ctrl_tb.sv
module nest_irq_ctrl_tb;
  localparam int N  = 8;
  localparam int LW = 3;
  localparam int IW = 3;
  localparam int RW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  irq_req = '0;
  logic [N*LW-1:0] irq_prio = '0;
  logic          eret = 1'b0;
  logic          sw_wr = 1'b0;
  logic [1:0]    sw_addr = 2'd0;
  logic [RW-1:0] sw_wdata = '0;
  logic [RW-1:0] sw_rdata;
  logic          ack;
  logic [IW-1:0] ack_id;
  logic [LW-1:0] ack_lvl;
  logic [LW-1:0] cur_mask;
  logic          exl;
  logic          ie;
  logic          stk_ovf;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  nest_irq_ctrl #(.N_SRC(N), .LVL_W(LW), .STK_DEPTH(4)) u_dut (
    .clk(clk), .rst(rst), .irq_req(irq_req), .irq_prio(irq_prio),
    .eret(eret), .sw_wr(sw_wr), .sw_addr(sw_addr), .sw_wdata(sw_wdata),
    .sw_rdata(sw_rdata), .ack(ack), .ack_id(ack_id), .ack_lvl(ack_lvl),
    .cur_mask(cur_mask), .exl(exl), .ie(ie), .stk_ovf(stk_ovf)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string rq, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    sw_wr = 1'b1; sw_addr = a[1:0]; sw_wdata = d[RW-1:0];
    step();
    sw_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    sw_addr = a[1:0];
    step();
    v = int'(sw_rdata);
  endtask

  task automatic set_prio(input int i, input int l);
    irq_prio[i*LW +: LW] = l[LW-1:0];
  endtask

  task automatic do_eret();
    eret = 1'b1;
    step();
    eret = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1", "mask", int'(cur_mask), 0);
    chk("R1", "exl", int'(exl), 0);
    chk("R1", "ie", int'(ie), 0);
    chk("R1", "ovf", int'(stk_ovf), 0);
    chk("R1", "ack", int'(ack), 0);
    rd(2, v); chk("R1", "depth", v, 0);
    rd(1, v); chk("R1", "flags", v, 0);

    // R3: enable off blocks acceptance
    set_prio(3, 4); irq_req = 8'h08;
    step();
    chk("R3", "ack ie=0", int'(ack), 0);
    chk("R3", "exl ie=0", int'(exl), 0);

    // R8 / R9: enabling write blocks acceptance in its own cycle
    wr(1, 1);
    chk("R9", "ack during write", int'(ack), 0);
    chk("R8", "ie written", int'(ie), 1);
    step();
    chk("R5", "ack", int'(ack), 1);
    chk("R5", "ack_id", int'(ack_id), 3);
    chk("R5", "ack_lvl", int'(ack_lvl), 4);
    chk("R5", "mask", int'(cur_mask), 4);
    chk("R5", "exl", int'(exl), 1);
    irq_req = '0;
    step();
    chk("R5", "ack pulse width", int'(ack), 0);
    rd(2, v); chk("R7", "depth after push", v, 1);

    // R6 return pops
    do_eret();
    chk("R6", "exl after eret", int'(exl), 0);
    chk("R6", "mask popped", int'(cur_mask), 0);

    // R8 / R3: software sets exl, return reopens
    wr(1, 3);
    irq_req = 8'h08;
    step();
    chk("R3", "ack with exl=1", int'(ack), 0);
    rd(1, v); chk("R8", "flags read", v, 3);
    do_eret();
    chk("R3", "no ack in eret cycle", int'(ack), 0);
    chk("R6", "exl cleared", int'(exl), 0);
    chk("R6", "mask empty stack", int'(cur_mask), 0);
    step();
    chk("R6", "ack after return", int'(ack), 1);
    irq_req = '0;
    do_eret();

    // R6: empty stack keeps written mask
    wr(0, 5);
    chk("R8", "mask written", int'(cur_mask), 5);
    do_eret();
    chk("R6", "mask kept on empty eret", int'(cur_mask), 5);
    wr(0, 0);

    // R9: eret and write of exl in same cycle, eret wins
    sw_wr = 1'b1; sw_addr = 2'd1; sw_wdata = 3'd3; eret = 1'b1;
    step();
    sw_wr = 1'b0; eret = 1'b0;
    chk("R9", "eret beats write", int'(exl), 0);

    // R4 nesting
    set_prio(1, 2); irq_req = 8'h02;
    step();
    chk("R4", "first level", int'(cur_mask), 2);
    irq_req = '0;
    wr(1, 1);
    set_prio(2, 2); irq_req = 8'h04;
    step();
    chk("R4", "equal level no ack", int'(ack), 0);
    set_prio(2, 5);
    step();
    chk("R4", "higher ack", int'(ack), 1);
    chk("R4", "higher id", int'(ack_id), 2);
    chk("R4", "nested mask", int'(cur_mask), 5);
    irq_req = '0;
    do_eret();
    chk("R6", "unwind one", int'(cur_mask), 2);
    do_eret();
    chk("R6", "unwind two", int'(cur_mask), 0);

    // R7 overflow
    for (int k = 1; k <= 5; k++) begin
      set_prio(0, k); irq_req = 8'h01;
      step();
      chk("R7", "nest ack", int'(ack), 1);
      chk("R7", "nest mask", int'(cur_mask), k);
      irq_req = '0;
      if (k < 5) wr(1, 1);
    end
    chk("R7", "ovf set", int'(stk_ovf), 1);
    rd(2, v); chk("R7", "depth full", v, 4);
    rd(1, v); chk("R7", "flags with ovf", v, 7);
    for (int k = 3; k >= 0; k--) begin
      do_eret();
      chk("R7", "pop order", int'(cur_mask), k);
    end
    do_eret();
    chk("R7", "pop empty", int'(cur_mask), 0);
    chk("R7", "ovf sticky", int'(stk_ovf), 1);
    rd(2, v); chk("R7", "depth empty", v, 0);

    // R2 / R4 sweep: all patterns, all masks
    for (int i = 0; i < N; i++) set_prio(i, ((i * 3) % 4) * 2);
    for (int m = 0; m < 8; m++) begin
      for (int pat = 1; pat < 256; pat++) begin
        int best_l;
        int best_i;
        wr(0, m);
        best_l = 0; best_i = -1;
        for (int i = 0; i < N; i++) begin
          int l;
          l = ((i * 3) % 4) * 2;
          if (pat[i] && l != 0 && l > m && l > best_l) begin
            best_l = l; best_i = i;
          end
        end
        irq_req = pat[N-1:0];
        step();
        irq_req = '0;
        if (best_i >= 0) begin
          chk("R2", "sweep ack", int'(ack), 1);
          chk("R2", "sweep id", int'(ack_id), best_i);
          chk("R2", "sweep lvl", int'(ack_lvl), best_l);
          do_eret();
          chk("R6", "sweep restore", int'(cur_mask), m);
        end else begin
          chk("R4", "sweep no ack", int'(ack), 0);
          chk("R4", "sweep mask held", int'(cur_mask), m);
        end
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule